// File: doc/BRIEF.md
# Four-Phase Condition-Steered Request Router

This block takes one return-to-zero (four-phase) request channel and sends each handshake to one of two downstream channels, a "true" branch or a "false" branch, chosen by a boolean condition input. Every handshake wire is a level that the block samples once per clock, and reset is synchronous. The block does not carry data. Only the control wires pass through it.

The condition is captured in the cycle where an idle router first sees the request high. It is held until the selected branch has dropped its acknowledge. Both the rising and the falling edge of one request therefore leave on the same branch. This holds even when the upstream stage changes the condition as soon as it sees the acknowledge rise. The acknowledge of the selected branch is passed back upstream, and the acknowledge of the other branch is ignored. Upstream sees one merged channel with the usual order: request up, acknowledge up, request down, acknowledge down. All wires are active high.

Top module: `steer4_select`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `req_true`, `req_false` and `ack_up` are all 0 and the router is idle.
- R2: When the idle router samples `req_in`=1, it captures `cond_in` at that same edge. One cycle later `req_true`=1 if `cond_in` was 1, or `req_false`=1 if it was 0.
- R3: Once a request has been sent on a branch, the edge that samples `req_in`=0 drives that same branch's request low one cycle later. The request never moves to the other branch.
- R4: Changes on `cond_in` after the capture, including changes during the return-to-zero phase, have no effect on which branch is driven.
- R5: `req_true` and `req_false` are never both 1.
- R6: While a handshake is in progress, `ack_up` equals the acknowledge input of the selected branch, combinationally.
- R7: The acknowledge of the branch that was not selected has no effect on `ack_up`.
- R8: The captured condition is released only at the edge that samples the selected acknowledge low. A `req_in`=1 seen before that edge starts no new handshake, and the next request is accepted at the following edge.
- R9: While idle, `ack_up` is 0 whatever the two acknowledge inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 1 | Upstream request level |
| cond_in | input | 1 | Branch condition (1 = true branch) |
| ack_up | output | 1 | Merged acknowledge to upstream |
| req_true | output | 1 | Request to the true branch |
| ack_true | input | 1 | Acknowledge from the true branch |
| req_false | output | 1 | Request to the false branch |
| ack_false | input | 1 | Acknowledge from the false branch |

## Verification
A corrupted captured condition would show up one cycle after the request falls. The wrong branch would be driven, or the falling edge would land on the other branch's request. That is visible at the next sample after the change on `cond_in`. A control state stuck busy or released early would show the same cycle on `ack_up`. In that case `ack_up` either follows the wrong branch's acknowledge or stays high while idle. A premature release would also let an early `req_in` start a handshake one cycle too soon. The stimulus toggles the condition just after the acknowledge rises, holds the request high during the drain phase, and drives the unselected acknowledge high, so each of these faults reaches a port.

// File: rtl/steer4_pkg.sv
// Shared types for the four-phase condition-steered router.
package steer4_pkg;

    // Control phase of one handshake.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for a request level
        PH_FWD   = 2'd1,   // request forwarded on the chosen branch
        PH_DRAIN = 2'd2    // request withdrawn, waiting for the branch ack to drop
    } phase_t;

endpackage

// File: rtl/steer4_fsm.sv
// Handshake phase sequencer.
// Moves through idle -> forward -> drain -> idle, one step per sampled
// level change. Assumes the inputs have already been synchronised to clk.
module steer4_fsm
    import steer4_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_in,
    input  logic   ack_sel,
    output phase_t phase,
    output logic   accept
);

    phase_t phase_nx;

    // Accept a request only from idle.
    assign accept = (phase == PH_IDLE) && req_in;

    // Next-phase decode.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (req_in)   phase_nx = PH_FWD;
            PH_FWD:   if (!req_in)  phase_nx = PH_DRAIN;
            PH_DRAIN: if (!ack_sel) phase_nx = PH_IDLE;
            default:                phase_nx = PH_IDLE;
        endcase
    end

    // Phase register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

endmodule

// File: rtl/steer4_capture.sv
// Condition holder.
// Loads the branch condition only when the sequencer accepts a request,
// and keeps it through the whole handshake.
module steer4_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic cond_in,
    output logic sel
);

    // Capture on accept, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= 1'b0;
        else if (accept) sel <= cond_in;
    end

endmodule

// File: rtl/steer4_route.sv
// Branch router.
// Drives the request of the captured branch while forwarding, and picks
// that branch's acknowledge for the merged upstream acknowledge.
// Purely combinational; relies on phase/sel being registered.
module steer4_route
    import steer4_pkg::*;
(
    input  phase_t phase,
    input  logic   sel,
    input  logic   ack_true,
    input  logic   ack_false,
    output logic   req_true,
    output logic   req_false,
    output logic   ack_sel,
    output logic   ack_up
);

    logic fwd;
    logic busy;

    // Request steering and acknowledge selection.
    always_comb begin
        fwd       = (phase == PH_FWD);
        busy      = (phase != PH_IDLE);
        req_true  = fwd &&  sel;
        req_false = fwd && !sel;
        ack_sel   = sel ? ack_true : ack_false;
        ack_up    = busy && ack_sel;
    end

endmodule

// File: rtl/steer4_select.sv
// Four-phase condition-steered request router (top).
// Sends each return-to-zero handshake to the true or false branch, chosen
// by the condition sampled when the request is accepted. Handshake wires
// are levels sampled on clk; reset is synchronous, active low.
module steer4_select
    import steer4_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic cond_in,
    output logic ack_up,
    output logic req_true,
    input  logic ack_true,
    output logic req_false,
    input  logic ack_false
);

    phase_t phase;
    logic   accept;
    logic   sel;
    logic   ack_sel;

    steer4_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .ack_sel (ack_sel),
        .phase   (phase),
        .accept  (accept)
    );

    steer4_capture u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .cond_in (cond_in),
        .sel     (sel)
    );

    steer4_route u_route (
        .phase     (phase),
        .sel       (sel),
        .ack_true  (ack_true),
        .ack_false (ack_false),
        .req_true  (req_true),
        .req_false (req_false),
        .ack_sel   (ack_sel),
        .ack_up    (ack_up)
    );

endmodule

// File: rtl/steer4_select_chk.sv
// Port-level protocol checker for steer4_select, attached by bind.
module steer4_select_chk (
    input logic clk,
    input logic rst_n,
    input logic req_in,
    input logic ack_up,
    input logic req_true,
    input logic ack_true,
    input logic req_false,
    input logic ack_false
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!req_true && !req_false && !ack_up)); // R1

    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_true, req_false})); // R5

    AST_TRUE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_true |=> !req_false); // R3

    AST_FALSE_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        req_false |=> !req_true); // R4

    AST_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_true || req_false) && !req_in) |=> (!req_true && !req_false)); // R3

    AST_ACK_TRUE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        req_true |-> (ack_up == ack_true)); // R6

    AST_ACK_FALSE_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        req_false |-> (ack_up == ack_false)); // R7

endmodule

bind steer4_select steer4_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .ack_up    (ack_up),
    .req_true  (req_true),
    .ack_true  (ack_true),
    .req_false (req_false),
    .ack_false (ack_false)
);

// File: tb/test_steer4_select.sv
`timescale 1ns/1ps
module test_steer4_select;

    logic clk = 1'b0;
    logic rst_n, req_in, cond_in, ack_true, ack_false;
    logic ack_up, req_true, req_false;
    int   n_run = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2.5 clk = ~clk;

    steer4_select i_steer4_select (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .cond_in(cond_in),
        .ack_up(ack_up), .req_true(req_true), .ack_true(ack_true),
        .req_false(req_false), .ack_false(ack_false)
    );

    // {req, cond, ack_t, ack_f, exp req_true, exp req_false, exp ack_up}
    localparam int NV = 15;
    localparam logic [6:0] VEC [0:NV-1] = '{
        7'b1100_100,  // accept, cond 1 -> true branch (R2)
        7'b1010_101,  // cond flips after ack rise (R4, R6)
        7'b0010_001,  // fall follows true branch (R3, R4)
        7'b0100_000,  // ack low -> idle (R8)
        7'b1000_010,  // cond 0 -> false branch (R2)
        7'b1110_010,  // unselected ack high ignored (R7)
        7'b1101_011,  // selected ack forwarded (R6)
        7'b0101_001,  // fall follows false branch (R3)
        7'b0011_001,  // drain holds, cond flip ignored (R4, R7)
        7'b1001_001,  // early req in drain not accepted (R8)
        7'b1100_000,  // ack low releases -> idle (R8)
        7'b1100_100,  // next request accepted (R8, R2)
        7'b1110_101,  // ack forward (R6)
        7'b0010_001,  // fall (R3)
        7'b0000_000   // back to idle (R9)
    };

    function automatic string tag_of(int i);
        case (i)
            0, 4:      return "R2";
            1, 8:      return "R4";
            2, 7, 13:  return "R3";
            5:         return "R7";
            6, 12:     return "R6";
            3, 9, 10, 11: return "R8";
            default:   return "R9";
        endcase
    endfunction

    task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {req_true,req_false,ack_up} actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic apply(logic r, logic c, logic at, logic af);
        @(negedge clk);
        req_in = r; cond_in = c; ack_true = at; ack_false = af;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_run++; n_bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; req_in = 1'b0; cond_in = 1'b0; ack_true = 1'b0; ack_false = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {req_true, req_false, ack_up}, 3'b000);
        @(negedge clk) rst_n = 1'b1;

        // Vector walk: drive at a falling edge, check one rising edge later.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            @(negedge clk);
            check(tag_of(i), {req_true, req_false, ack_up}, VEC[i][2:0]);
        end

        // R9: idle with both acks high keeps ack_up low.
        apply(1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R9", {req_true, req_false, ack_up}, 3'b000);

        // R1: reset in the middle of a handshake.
        apply(1'b0, 1'b0, 1'b0, 1'b0);
        apply(1'b1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2", {req_true, req_false, ack_up}, 3'b010);
        rst_n = 1'b0; ack_false = 1'b1;
        @(negedge clk);
        check("R1", {req_true, req_false, ack_up}, 3'b000);
        rst_n = 1'b1; req_in = 1'b0; ack_false = 1'b0;
        @(negedge clk);
        check("R1", {req_true, req_false, ack_up}, 3'b000);

        done = 1'b1;
        finish_run();
    end

endmodule